// File: doc/BRIEF.md
# Two-Requester Bus Arbiter with Turnaround Gap

This block decides which of two serial memory controllers owns a single shared external memory bus. Each controller raises its request line to ask for the bus and keeps it high for as long as it needs the bus. The arbiter answers by raising that controller's acknowledge line, and it never takes the bus away. A controller gives the bus back by dropping its request. The arbiter then waits a programmable turnaround gap, with both acknowledges low, before it grants the bus again.

When both controllers are waiting at the moment a grant is made, a round-robin pointer favours the one that did not own the bus last. Each controller is expected to bound its own request time, so fairness is kept without any preemption. A multiplex-enable input turns arbitration on. While it is low, no grant is issued. The block also drives an owner-valid flag and an owner index, which steer the downstream data-path multiplexer.

Top module: `bus_turnaround_arbiter`

## Requirements
- R1: After reset, both acknowledges are low, owner_valid is 0 and owner_idx is 0.
- R2: From idle with arbitration enabled, a request that is first sampled high at a clock edge is acknowledged starting from that same edge, and not before it.
- R3: While the owner keeps its request high and the enable stays 1, its acknowledge stays high. A request from the other requester does not take the bus away.
- R4: The owner's acknowledge goes low in the same cycle that its request goes low, with no clock edge between them.
- R5: With turnaround value G (8 bits, cycles minus one), let edge k be the first clock edge at which the release is sampled. No acknowledge is high through edge k+G. A waiting requester is acknowledged from edge k+G+1.
- R6: When both requesters are waiting at a grant decision, the one that did not receive the previous grant wins. After reset, requester 1 (req[0]) wins the first such tie.
- R7: If only one requester is waiting when the gap ends, it is granted, even if it was the previous owner.
- R8: While mux_en is 0, no acknowledge is issued. If mux_en is 0 at a clock edge, any grant held is withdrawn from that edge.
- R9: The two acknowledges are never high at the same time.
- R10: owner_valid is 1 exactly when one acknowledge is high. owner_idx is then 0 for requester 1 (ack[0]) and 1 for requester 2 (ack[1]).
- R11: The turnaround value is captured at the release edge. Changing gap_cfg during the gap does not change when the next grant occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_en | input | 1 | Arbitration enable; 0 means no grants |
| gap_cfg | input | 8 | Turnaround length, in cycles minus one |
| req | input | 2 | Requests; bit 0 is requester 1, bit 1 is requester 2 |
| ack | output | 2 | Acknowledges, one per requester |
| owner_valid | output | 1 | An owner currently holds the bus |
| owner_idx | output | 1 | Index of the current owner (0 is requester 1) |

## Verification
The embedded properties are checked on every cycle. They cover mutual exclusion of the acknowledges, holding the owner without preemption, entry into the gap on release, decrement of the gap counter with no grant while it is non-zero, the pointer flip after each grant, and withdrawal when the enable is low. Some behaviour can only be shown by the directed scenarios: the exact edge at which the grant lands after a gap of a given length, the same-cycle drop of the acknowledge, tie breaking on the very first grant, regrant of the previous owner, and immunity to gap_cfg changes made mid-gap.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_GAP   = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       owner;
    } fsm_regs_t;

endpackage

// File: rtl/arb_gap_counter.sv
module arb_gap_counter #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    localparam logic [GAP_W-1:0] CNT_ZERO = '0;

    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != CNT_ZERO)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_ZERO;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_ZERO);

    // R5: the gap counter steps down by exactly one per cycle while it is running
    assert_gap_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/arb_rr_pointer.sv
module arb_rr_pointer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       grant_fire,
    input  logic       grant_idx,
    output logic       pick_valid,
    output logic       pick_idx
);
    logic favour_d, favour_q;

    always_comb begin
        favour_d = favour_q;
        if (grant_fire) favour_d = ~grant_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) favour_q <= 1'b0;
        else        favour_q <= favour_d;
    end

    always_comb begin
        pick_valid = |req;
        if (req == 2'b11) pick_idx = favour_q;
        else              pick_idx = req[1];
    end

    // R6: after each grant the tie-break favours the other requester
    assert_rr_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> (favour_q == ~$past(grant_idx)));

endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mux_en,
    input  logic [1:0] req,
    input  logic       pick_valid,
    input  logic       pick_idx,
    input  logic       gap_done,
    output logic       gap_load,
    output logic       gap_run,
    output logic       grant_fire,
    output logic       granted,
    output logic       owner
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        gap_load   = 1'b0;
        grant_fire = 1'b0;
        if (!mux_en) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (pick_valid) begin
                        r_d.state  = ST_GRANT;
                        r_d.owner  = pick_idx;
                        grant_fire = 1'b1;
                    end
                end
                ST_GRANT: begin
                    if (!req[r_q.owner]) begin
                        r_d.state = ST_GAP;
                        gap_load  = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        if (pick_valid) begin
                            r_d.state  = ST_GRANT;
                            r_d.owner  = pick_idx;
                            grant_fire = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.owner <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gap_run = (r_q.state == ST_GAP);
    assign granted = (r_q.state == ST_GRANT);
    assign owner   = r_q.owner;

    // R3: no preemption while the owner holds its request
    assert_no_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GRANT && req[r_q.owner] && mux_en)
        |=> (r_q.state == ST_GRANT && r_q.owner == $past(r_q.owner)));

    // R5: a release always enters the turnaround gap
    assert_release_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GRANT && !req[r_q.owner] && mux_en) |=> (r_q.state == ST_GAP));

    // R5: no grant while the gap has not run out
    assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GAP && !gap_done) |=> (r_q.state != ST_GRANT));

    // R8: disable withdraws any grant
    assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_en |=> (r_q.state == ST_IDLE));

endmodule

// File: rtl/bus_turnaround_arbiter.sv
module bus_turnaround_arbiter #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mux_en,
    input  logic [GAP_W-1:0] gap_cfg,
    input  logic [1:0]       req,
    output logic [1:0]       ack,
    output logic             owner_valid,
    output logic             owner_idx
);
    logic gap_load, gap_run, gap_done;
    logic grant_fire, granted, owner;
    logic pick_valid, pick_idx;

    arb_gap_counter #(.GAP_W(GAP_W)) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_cfg),
        .run      (gap_run),
        .done     (gap_done)
    );

    arb_rr_pointer rr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .grant_fire (grant_fire),
        .grant_idx  (pick_idx),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    arb_grant_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_en     (mux_en),
        .req        (req),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .gap_done   (gap_done),
        .gap_load   (gap_load),
        .gap_run    (gap_run),
        .grant_fire (grant_fire),
        .granted    (granted),
        .owner      (owner)
    );

    // The acknowledge follows the owner's request, so a release drops it at once
    for (genvar g = 0; g < 2; g++) begin : g_ack
        assign ack[g] = granted && (owner == g[0]) && req[g];
    end

    assign owner_valid = |ack;
    assign owner_idx   = owner;

    // R9: the two acknowledges are never high together
    assert_ack_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    // R8: a low enable leaves no acknowledge in the following cycle
    assert_disabled_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_en |=> (ack == 2'b00));

endmodule

// File: tb/bus_turnaround_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_turnaround_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mux_en;
    logic [7:0] gap_cfg;
    logic [1:0] req;
    logic [1:0] ack;
    logic       owner_valid;
    logic       owner_idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_turnaround_arbiter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux_en      (mux_en),
        .gap_cfg     (gap_cfg),
        .req         (req),
        .ack         (ack),
        .owner_valid (owner_valid),
        .owner_idx   (owner_idx)
    );

    // R9 monitor: mutual exclusion counted at every sample point
    int both_high = 0;
    always @(negedge clk) if (rst_n && ack == 2'b11) both_high++;

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // exp_ack: expected ack; owner fields derived per R10
    task automatic see(input string tag, input logic [1:0] exp_ack);
        logic [3:0] got, exp;
        got = {owner_valid, owner_valid & owner_idx, ack};
        exp = {|exp_ack, exp_ack[1], exp_ack};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {valid,idx,ack} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 2'b00; mux_en = 1'b1; gap_cfg = 8'd0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        see("R1 reset idle", 2'b00);
    endtask

    task automatic t_single_hold_release();
        do_reset();
        gap_cfg = 8'd3;
        req = 2'b01;
        #0.5;
        see("R2 no ack before edge", 2'b00);
        step();
        see("R2 grant req1", 2'b01);
        req = 2'b11;
        for (int i = 0; i < 5; i++) begin
            step();
            see("R3 hold owner", 2'b01);
        end
        req = 2'b10;
        #0.5;
        see("R4 same-cycle drop", 2'b00);
        for (int i = 0; i < 4; i++) begin
            step();
            see("R5 gap G=3 idle", 2'b00);
        end
        step();
        see("R5 grant after gap G=3", 2'b10);
    endtask

    task automatic t_gap_zero();
        do_reset();
        gap_cfg = 8'd0;
        req = 2'b10;
        step();
        see("R2 grant req2", 2'b10);
        req = 2'b01;
        step();
        see("R5 gap G=0 idle", 2'b00);
        step();
        see("R5 grant after gap G=0", 2'b01);
    endtask

    task automatic t_round_robin();
        do_reset();
        gap_cfg = 8'd1;
        req = 2'b11;
        step();
        see("R6 first tie to req1", 2'b01);
        req = 2'b10;
        step();
        see("R5 gap idle a", 2'b00);
        req = 2'b11;
        step();
        see("R5 gap idle b", 2'b00);
        step();
        see("R6 tie goes to req2", 2'b10);
        req = 2'b01;
        step();
        see("R5 gap idle c", 2'b00);
        req = 2'b11;
        step();
        see("R5 gap idle d", 2'b00);
        step();
        see("R6 tie back to req1", 2'b01);
    endtask

    task automatic t_same_owner();
        do_reset();
        gap_cfg = 8'd2;
        req = 2'b10;
        step();
        see("R7 initial grant req2", 2'b10);
        req = 2'b00;
        step();
        see("R7 gap idle", 2'b00);
        req = 2'b10;
        step();
        see("R7 gap idle", 2'b00);
        step();
        see("R7 gap idle", 2'b00);
        step();
        see("R7 regrant previous owner", 2'b10);
    endtask

    task automatic t_enable();
        do_reset();
        mux_en = 1'b0;
        req = 2'b01;
        for (int i = 0; i < 3; i++) begin
            step();
            see("R8 disabled no ack", 2'b00);
        end
        mux_en = 1'b1;
        step();
        see("R8 grant on enable", 2'b01);
        mux_en = 1'b0;
        step();
        see("R8 withdrawn on disable", 2'b00);
    endtask

    task automatic t_cfg_latched();
        do_reset();
        gap_cfg = 8'd4;
        req = 2'b01;
        step();
        see("R11 grant req1", 2'b01);
        req = 2'b10;
        step();
        gap_cfg = 8'd0;
        see("R11 gap idle", 2'b00);
        for (int i = 0; i < 4; i++) begin
            step();
            see("R11 gap idle after cfg change", 2'b00);
        end
        step();
        see("R11 grant at latched gap", 2'b10);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single_hold_release();
        t_gap_zero();
        t_round_robin();
        t_same_owner();
        t_enable();
        t_cfg_latched();
        checks++;
        if (both_high != 0) begin
            errors++;
            $display("FAIL R9: both acks high count got %0d expected 0", both_high);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule